// File: doc/BRIEF.md
# Low-Power Burst Mode Supervisor

This block decides, once per master clock period, whether the downstream converter may fire its pulse and whether the boost front end that charges the bus runs. It watches two digitized levels: the duty command, which tracks how much power the converter delivers, and the bus feedback, which tracks the bus voltage. When the load is light, the block switches to a burst regime. The front end stays off, and the converter fires only in those master periods where the duty command has climbed back above a higher threshold. This skips pulses in step with the master clock. The front end comes back on when the bus sags. Each time it does, the block returns to normal mode. Burst mode resumes only if the command is still low once the bus is full again.

Samples arrive on one valid/ready stream that carries the command code and the feedback code together. `smp_ready` is high exactly in master-tick cycles, so the block consumes at most one sample per master period. A producer holds its sample and `smp_valid` until a cycle where both are high. Back-pressure costs the producer nothing but waiting, and no sample is lost. All five thresholds are unsigned configuration codes. All outputs are registered and change only on the clock edge that accepts a sample.

Top module: `burst_supervisor`

## Requirements
- R1: After reset the outputs are: `pulse_permit`=0, `boost_en`=1, `burst_mode`=0, `ovp_flag`=0, `input_ready`=0.
- R2: A sample is accepted only on a rising edge where `smp_valid` and `smp_ready` are both 1, and `smp_ready` equals `tick`. In all other cycles, including ticks with no valid sample, every output keeps its value.
- R3: `input_ready` sets on the first accepted sample with feedback >= `cfg_fb_high` and then stays set. `pulse_permit` is never 1 while `input_ready` is 0.
- R4: In normal mode, an accepted sample with feedback >= `cfg_fb_high` and command < `cfg_enter` puts the block into burst mode (`burst_mode`=1) on that edge.
- R5: In burst mode, an accepted sample that keeps the block in burst sets `pulse_permit` to 1 when command >= `cfg_pulse`. Otherwise it clears `pulse_permit` to 0, which skips that period's pulse.
- R6: While `burst_mode` is 1, `boost_en` is 0.
- R7: In burst mode, an accepted sample with feedback < `cfg_fb_low` clears `burst_mode` and turns the front end on (`boost_en`=1) on that edge. The next entry to burst mode again requires the condition of R4.
- R8: In normal mode each accepted sample sets `pulse_permit` to `input_ready`'s new value. `boost_en` is 1 unless `ovp_flag` is set.
- R9: An accepted sample with feedback > `cfg_fb_ovp` sets `ovp_flag`. A sample with feedback < `cfg_fb_high` clears it. Samples in between leave it unchanged. While `ovp_flag` is 1, `boost_en` is 0 in any mode.
- R10: All comparisons are unsigned with these boundaries: a command equal to `cfg_pulse` permits, a command equal to `cfg_enter` does not enter burst, feedback equal to `cfg_fb_high` counts as reached, feedback equal to `cfg_fb_low` does not end burst, and feedback equal to `cfg_fb_ovp` does not trip the overvoltage flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle master-period tick |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready (equals tick) |
| smp_cmd | input | W | Duty-command sample code |
| smp_fb | input | W | Bus feedback sample code |
| cfg_enter | input | W | Lower command threshold (burst entry) |
| cfg_pulse | input | W | Higher command threshold (pulse in burst) |
| cfg_fb_low | input | W | Feedback level that starts a recharge |
| cfg_fb_high | input | W | Feedback level counted as bus full |
| cfg_fb_ovp | input | W | Feedback overvoltage level |
| pulse_permit | output | 1 | Converter pulse allowed this period |
| boost_en | output | 1 | Front-end boost stage enable |
| burst_mode | output | 1 | Burst regime active |
| ovp_flag | output | 1 | Overvoltage latched |
| input_ready | output | 1 | Bus has reached full level once |

## Verification
The bench builds the block with W=6, so every code lies in 0..63. The thresholds are set to 20, 26, 36, 40 and 44. At this width a long pseudo-random stream of command and feedback pairs lands on every threshold boundary many times. It also walks the block through repeated entry, skip, recharge, exit and overvoltage cycles. Random wait times before acceptance and idle ticks probe the hold behaviour, and a directed prologue pins each boundary equality.

// File: rtl/burst_sup_pkg.sv
package burst_sup_pkg;
  typedef enum logic [0:0] {
    MODE_NORMAL = 1'b0,
    MODE_BURST  = 1'b1
  } mode_e;

  localparam int CMD_IDX_ENTER = 0;
  localparam int CMD_IDX_PULSE = 1;
  localparam int FB_IDX_LOW    = 0;
  localparam int FB_IDX_HIGH   = 1;
  localparam int N_CMD_THR     = 2;
  localparam int N_FB_THR      = 2;
endpackage

// File: rtl/burst_sup_cmp.sv
module burst_sup_cmp #(
  parameter int W = 10,
  parameter int N = 2
) (
  input  logic [W-1:0]        level,
  input  logic [N-1:0][W-1:0] thr,
  output logic [N-1:0]        below
);
  // one unsigned "strictly below" comparator per threshold
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign below[g] = (level < thr[g]);
  end
endmodule

// File: rtl/burst_sup_guard.sv
module burst_sup_guard #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] fb,
  input  logic [W-1:0] thr_ovp,
  input  logic         fb_below_high,
  output logic         ovp_nx,
  output logic         rdy_nx,
  output logic         ovp_flag,
  output logic         input_ready
);
  logic ovp_q, rdy_q;
  logic fb_over;

  assign fb_over = (fb > thr_ovp);

  always_comb begin
    ovp_nx = ovp_q;
    rdy_nx = rdy_q;
    if (accept) begin
      if (fb_over)            ovp_nx = 1'b1;
      else if (fb_below_high) ovp_nx = 1'b0;
      if (!fb_below_high)     rdy_nx = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovp_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      ovp_q <= ovp_nx;
      rdy_q <= rdy_nx;
    end
  end

  assign ovp_flag    = ovp_q;
  assign input_ready = rdy_q;

  p_ovp_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fb_over) |=> ovp_flag);
  p_ovp_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fb_below_high) |=> !ovp_flag);
  p_ready_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    input_ready |=> input_ready);
endmodule

// File: rtl/burst_sup_fsm.sv
module burst_sup_fsm
  import burst_sup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic cmd_below_enter,
  input  logic cmd_below_pulse,
  input  logic fb_below_low,
  input  logic fb_below_high,
  input  logic ovp_nx,
  input  logic rdy_nx,
  output logic pulse_permit,
  output logic boost_en,
  output logic burst_mode
);
  mode_e mode_q, mode_nx;
  logic  permit_q, permit_nx;
  logic  boost_q, boost_nx;

  always_comb begin
    mode_nx = mode_q;
    if (accept) begin
      unique case (mode_q)
        MODE_NORMAL: if (!fb_below_high && cmd_below_enter) mode_nx = MODE_BURST;
        MODE_BURST:  if (fb_below_low)                      mode_nx = MODE_NORMAL;
        default:     mode_nx = MODE_NORMAL;
      endcase
    end
  end

  always_comb begin
    permit_nx = permit_q;
    boost_nx  = boost_q;
    if (accept) begin
      if (mode_nx == MODE_BURST) begin
        permit_nx = rdy_nx && !cmd_below_pulse;
        boost_nx  = 1'b0;
      end else begin
        permit_nx = rdy_nx;
        boost_nx  = !ovp_nx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_NORMAL;
      permit_q <= 1'b0;
      boost_q  <= 1'b1;
    end else begin
      mode_q   <= mode_nx;
      permit_q <= permit_nx;
      boost_q  <= boost_nx;
    end
  end

  assign pulse_permit = permit_q;
  assign boost_en     = boost_q;
  assign burst_mode   = (mode_q == MODE_BURST);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable({pulse_permit, boost_en, burst_mode}));
  p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !burst_mode && !fb_below_high && cmd_below_enter) |=> burst_mode);
  p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && burst_mode && !fb_below_low && cmd_below_pulse) |=> !pulse_permit);
  p_burst_boost_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode |-> !boost_en);
  p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && burst_mode && fb_below_low) |=> (!burst_mode && boost_en));
endmodule

// File: rtl/burst_supervisor.sv
module burst_supervisor
  import burst_sup_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_cmd,
  input  logic [W-1:0] smp_fb,
  input  logic [W-1:0] cfg_enter,
  input  logic [W-1:0] cfg_pulse,
  input  logic [W-1:0] cfg_fb_low,
  input  logic [W-1:0] cfg_fb_high,
  input  logic [W-1:0] cfg_fb_ovp,
  output logic         pulse_permit,
  output logic         boost_en,
  output logic         burst_mode,
  output logic         ovp_flag,
  output logic         input_ready
);
  logic                       accept;
  logic [N_CMD_THR-1:0][W-1:0] cmd_thr;
  logic [N_FB_THR-1:0][W-1:0]  fb_thr;
  logic [N_CMD_THR-1:0]        cmd_below;
  logic [N_FB_THR-1:0]         fb_below;
  logic                        ovp_nx, rdy_nx;

  assign smp_ready = tick;
  assign accept    = smp_valid && tick;

  always_comb begin
    cmd_thr[CMD_IDX_ENTER] = cfg_enter;
    cmd_thr[CMD_IDX_PULSE] = cfg_pulse;
    fb_thr[FB_IDX_LOW]     = cfg_fb_low;
    fb_thr[FB_IDX_HIGH]    = cfg_fb_high;
  end

  burst_sup_cmp #(.W(W), .N(N_CMD_THR)) i_cmd_cmp (
    .level (smp_cmd),
    .thr   (cmd_thr),
    .below (cmd_below)
  );

  burst_sup_cmp #(.W(W), .N(N_FB_THR)) i_fb_cmp (
    .level (smp_fb),
    .thr   (fb_thr),
    .below (fb_below)
  );

  burst_sup_guard #(.W(W)) i_guard (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .fb            (smp_fb),
    .thr_ovp       (cfg_fb_ovp),
    .fb_below_high (fb_below[FB_IDX_HIGH]),
    .ovp_nx        (ovp_nx),
    .rdy_nx        (rdy_nx),
    .ovp_flag      (ovp_flag),
    .input_ready   (input_ready)
  );

  burst_sup_fsm i_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .accept          (accept),
    .cmd_below_enter (cmd_below[CMD_IDX_ENTER]),
    .cmd_below_pulse (cmd_below[CMD_IDX_PULSE]),
    .fb_below_low    (fb_below[FB_IDX_LOW]),
    .fb_below_high   (fb_below[FB_IDX_HIGH]),
    .ovp_nx          (ovp_nx),
    .rdy_nx          (rdy_nx),
    .pulse_permit    (pulse_permit),
    .boost_en        (boost_en),
    .burst_mode      (burst_mode)
  );

  p_permit_needs_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_permit |-> input_ready);
  p_ovp_blocks_boost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_flag |-> !boost_en);
  p_ready_is_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready == tick);
endmodule

// File: tb/test_burst_supervisor.sv
`timescale 1ns/1ps
module test_burst_supervisor;
  localparam int W   = 6;
  localparam int EN  = 20;
  localparam int PU  = 26;
  localparam int LO  = 36;
  localparam int HI  = 40;
  localparam int OVP = 44;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         smp_valid = 1'b0;
  logic         smp_ready;
  logic [W-1:0] smp_cmd = '0;
  logic [W-1:0] smp_fb = '0;
  logic         pulse_permit, boost_en, burst_mode, ovp_flag, input_ready;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  bit m_permit, m_boost, m_burst, m_ovp, m_rdy;

  always #4 clk = ~clk;

  burst_supervisor #(.W(W)) i_burst_supervisor (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .smp_valid    (smp_valid),
    .smp_ready    (smp_ready),
    .smp_cmd      (smp_cmd),
    .smp_fb       (smp_fb),
    .cfg_enter    (W'(EN)),
    .cfg_pulse    (W'(PU)),
    .cfg_fb_low   (W'(LO)),
    .cfg_fb_high  (W'(HI)),
    .cfg_fb_ovp   (W'(OVP)),
    .pulse_permit (pulse_permit),
    .boost_en     (boost_en),
    .burst_mode   (burst_mode),
    .ovp_flag     (ovp_flag),
    .input_ready  (input_ready)
  );

  task automatic chk(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, " R5 pulse_permit"}, pulse_permit, m_permit);
    chk({ctx, " R6 boost_en"},     boost_en,     m_boost);
    chk({ctx, " R4 burst_mode"},   burst_mode,   m_burst);
    chk({ctx, " R9 ovp_flag"},     ovp_flag,     m_ovp);
    chk({ctx, " R3 input_ready"},  input_ready,  m_rdy);
  endtask

  // requirement-level model: R3, R4, R5, R7, R8, R9, R10
  task automatic model(input int c, input int f);
    if (f > OVP) m_ovp = 1'b1;
    else if (f < HI) m_ovp = 1'b0;
    if (f >= HI) m_rdy = 1'b1;
    if (!m_burst) begin
      if (f >= HI && c < EN) m_burst = 1'b1;
    end else if (f < LO) begin
      m_burst = 1'b0;
    end
    m_permit = m_rdy && (!m_burst || c >= PU);
    m_boost  = !m_burst && !m_ovp;
  endtask

  // called at a negedge; waits 'waits' non-tick cycles before the accepting tick
  task automatic send(input int c, input int f, input int waits, input string ctx);
    int w = waits;
    bit acc;
    smp_cmd = W'(c);
    smp_fb = W'(f);
    smp_valid = 1'b1;
    forever begin
      tick = (w == 0);
      chk("R2 smp_ready follows tick", smp_ready, tick);
      acc = tick;
      @(posedge clk);
      @(negedge clk);
      if (acc) break;
      w--;
      check_all({ctx, " R2 hold while waiting"});
    end
    smp_valid = 1'b0;
    tick = 1'b0;
    model(c, f);
    check_all(ctx);
  endtask

  task automatic idle_tick(input int c, input int f);
    smp_cmd = W'(c);
    smp_fb = W'(f);
    smp_valid = 1'b0;
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check_all("R2 idle tick ignored");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    m_permit = 1'b0; m_boost = 1'b1; m_burst = 1'b0; m_ovp = 1'b0; m_rdy = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");

    idle_tick(0, 63);                      // R2: tick without valid does nothing
    send(30, 30, 0, "R3 bus not full");
    send(10, 39, 2, "R4 no entry below full bus");
    send(30, 40, 1, "R10 fb equal high reaches full");
    send(20, 40, 0, "R10 cmd equal enter stays normal R8");
    send(19, 40, 0, "R4 entry");
    send(26, 40, 0, "R10 cmd equal pulse permits R5");
    send(25, 36, 1, "R10 fb equal low stays burst R5");
    idle_tick(63, 0);
    send(30, 35, 0, "R7 exit on sag");
    send(10, 35, 0, "R7 no re-entry before full");
    send(30, 44, 0, "R10 fb equal ovp no trip");
    send(30, 45, 0, "R9 ovp trip");
    send(30, 44, 2, "R9 ovp holds in band");
    send(10, 41, 0, "R9 burst with ovp R6");
    send(30, 39, 0, "R9 ovp clear");
    send(30, 30, 0, "R7 recharge exit");

    for (int k = 0; k < 6000; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[23:20] == 4'h0) idle_tick(int'(lf[5:0]), int'(lf[13:8]));
      send(int'(lf[5:0]), int'(lf[13:8]), int'(lf[17:16]), "sweep");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule